// File: doc/BRIEF.md
# Always-On Seconds Counter with Alarm

This block is a small register-mapped timekeeper for an always-on power domain. A 47-bit counter advances on every rising edge of a 32.768 kHz slow clock. Its upper 32 bits count whole seconds and its lower 15 bits count slow-clock ticks within the current second. Software reaches the block over a simple bus in a faster bus clock domain. The block offers a control word, a status word, the counter split over two words, a 32-bit alarm compare value in seconds, and a free 32-bit guard word that software writes with a known pattern and reads back.

To set the time, software stops the counter, writes the two counter words and starts the counter again. A request/acknowledge handshake carries the loaded value into the slow domain. The run, alarm and wakeup enables are written in the bus domain. The run enable crosses into the slow domain, and its readback returns only after it has come back through a second synchroniser. Counter reads come through a two-flop synchroniser, so software reads a pair twice and keeps the pair once two reads agree. When the alarm is armed and the seconds field equals the alarm value, a sticky flag sets. The interrupt line is that flag gated by the alarm enable and the wakeup enable.

Top module: `aon_sec_counter`

## Requirements
- R1: After reset, every readable word (control, status, both counter words, alarm, guard) reads 0 and `irq` is low.
- R2: Word offsets are control 0x04, status 0x18, counter high 0x1C, counter low 0x20, alarm 0x24 and guard 0x30. Other offsets read 0. The guard word stores any 32-bit value written to it, for example 0x41736166.
- R3: The counter is 47 bits wide. The low word is bits 31:0. The high word holds bits 46:32 in its bits 14:0, and its upper bits read 0. Seconds are bits 46:15. While running, the counter advances by one per slow-clock edge. While stopped, it holds its value.
- R4: Writes to either counter word take effect only while the counter is fully stopped, meaning control bit 0 is clear and its readback is clear. At any other time such a write is ignored.
- R5: Control bit 0 (run) reads back only after a round trip through the slow domain. The readback updates within 3 slow-clock cycles of the write and never in the write's own cycle. Control bit 1 (alarm enable) and bit 3 (wakeup enable) read back at once.
- R6: The alarm word can be written only while control bit 1 is clear. A write while bit 1 is set leaves it unchanged.
- R7: Status bit 0 sets when control bit 1 is set and the seconds field equals the alarm word. This includes the case where the two become equal because the alarm is enabled while the seconds already match. The flag does not set before the match.
- R8: Status bit 0 stays set until a status write with bit 0 at 1 clears it, and writing all ones clears it. A status write with bit 0 at 0 has no effect. Once cleared, the flag stays clear for the rest of the same matching second.
- R9: `irq` is high exactly when status bit 0, control bit 1 and control bit 3 are all set.
- R10: Counter reads cross through a synchroniser. A pair of high and low words that two consecutive reads return identically is a coherent snapshot of the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| slow_clk | input | 1 | 32.768 kHz counting clock |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high, read otherwise |
| bus_addr | input | 6 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Alarm interrupt / wakeup request |

## Verification
A counter that moves while stopped, or takes a write while running, shows up in the first coherent read of the counter words a few slow cycles later. A load lost in the handshake shows up the same way. A run readback that is missing or arrives early is caught by reading the control word at once after the write and again after three slow cycles. A flag that misses the match, sets early, fails to clear, or re-sets without a new match is visible on the status word and on `irq` within a few slow cycles of the seconds rollover or of the alarm being enabled.

// File: rtl/aon_sec_counter.sv
module aon_sec_counter #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_clk,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int CNT_W = SEC_W + FRAC_W;
  localparam int HI_W  = CNT_W - 32;
  localparam logic [5:0] A_CTRL  = 6'h04;
  localparam logic [5:0] A_STAT  = 6'h18;
  localparam logic [5:0] A_CNTHI = 6'h1C;
  localparam logic [5:0] A_CNTLO = 6'h20;
  localparam logic [5:0] A_ALARM = 6'h24;
  localparam logic [5:0] A_GUARD = 6'h30;

  // bus-domain state
  logic             run_q, alm_q, wake_q, flag;
  logic [SEC_W-1:0] alarm_q;
  logic [31:0]      guard_q;
  logic [CNT_W-1:0] set_val, cnt_m, cnt_b;
  logic             load_req, load_pend;
  logic [1:0]       run_bk_sy, ack_sy, match_sy;
  logic             match_d;

  // slow-domain state
  logic [1:0]       run_sy, alm_sy, req_sy;
  logic [CNT_W-1:0] cnt;
  logic             match_s;

  wire wr       = bus_sel && bus_wr;
  wire wr_ctrl  = wr && bus_addr == A_CTRL;
  wire wr_stat  = wr && bus_addr == A_STAT;
  wire wr_hi    = wr && bus_addr == A_CNTHI;
  wire wr_lo    = wr && bus_addr == A_CNTLO;
  wire wr_alarm = wr && bus_addr == A_ALARM;
  wire wr_guard = wr && bus_addr == A_GUARD;

  wire run_bk     = run_bk_sy[1];
  wire ack_b      = ack_sy[1];
  wire stopped    = !run_q && !run_bk;
  wire cnt_wr_ok  = (wr_hi || wr_lo) && stopped;
  wire match_rise = match_sy[1] && !match_d;

  wire run_s = run_sy[1];
  wire alm_s = alm_sy[1];
  wire req_s = req_sy[1];

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) begin
      run_sy  <= '0;
      alm_sy  <= '0;
      req_sy  <= '0;
      cnt     <= '0;
      match_s <= 1'b0;
    end else begin
      run_sy  <= {run_sy[0], run_q};
      alm_sy  <= {alm_sy[0], alm_q};
      req_sy  <= {req_sy[0], load_req};
      if (req_s && !run_s)
        cnt <= set_val;
      else if (run_s)
        cnt <= cnt + 1'b1;
      match_s <= alm_s && (cnt[CNT_W-1:FRAC_W] == alarm_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      alm_q     <= 1'b0;
      wake_q    <= 1'b0;
      alarm_q   <= '0;
      guard_q   <= '0;
      set_val   <= '0;
      load_req  <= 1'b0;
      load_pend <= 1'b0;
      run_bk_sy <= '0;
      ack_sy    <= '0;
      match_sy  <= '0;
      match_d   <= 1'b0;
      cnt_m     <= '0;
      cnt_b     <= '0;
      flag      <= 1'b0;
    end else begin
      run_bk_sy <= {run_bk_sy[0], run_s};
      ack_sy    <= {ack_sy[0], req_s};
      match_sy  <= {match_sy[0], match_s};
      match_d   <= match_sy[1];
      cnt_m     <= cnt;
      cnt_b     <= cnt_m;

      if (wr_ctrl) begin
        run_q  <= bus_wdata[0];
        alm_q  <= bus_wdata[1];
        wake_q <= bus_wdata[3];
      end
      if (wr_alarm && !alm_q) alarm_q <= bus_wdata[SEC_W-1:0];
      if (wr_guard) guard_q <= bus_wdata;

      if (cnt_wr_ok) begin
        if (wr_lo) set_val[31:0]       <= bus_wdata;
        else       set_val[CNT_W-1:32] <= bus_wdata[HI_W-1:0];
        if (!ack_b) load_req  <= 1'b1;
        else        load_pend <= 1'b1;
      end else if (load_req && ack_b) begin
        load_req <= 1'b0;
      end else if (load_pend && !ack_b && !load_req) begin
        load_req  <= 1'b1;
        load_pend <= 1'b0;
      end

      if (match_rise)                    flag <= 1'b1;
      else if (wr_stat && bus_wdata[0])  flag <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {28'b0, wake_q, 1'b0, alm_q, run_bk};
      A_STAT:  bus_rdata = {31'b0, flag};
      A_CNTHI: bus_rdata = {{(32-HI_W){1'b0}}, cnt_b[CNT_W-1:32]};
      A_CNTLO: bus_rdata = cnt_b[31:0];
      A_ALARM: bus_rdata = 32'(alarm_q);
      A_GUARD: bus_rdata = guard_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = flag && alm_q && wake_q;

  AST_CNT_HOLD: assert property (@(posedge slow_clk) disable iff (!rst_n)
    (!run_s && !req_s) |=> $stable(cnt)); // R3
  AST_CNT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_hi || wr_lo) && (run_q || run_bk)) |=> $stable(set_val)); // R4
  AST_ALARM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_alarm && alm_q) |=> $stable(alarm_q)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(wr_stat && bus_wdata[0])) |=> flag); // R8
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[0] && !match_rise) |=> !flag); // R8
  AST_GUARD_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_guard |=> (guard_q == $past(bus_wdata))); // R2
endmodule

// File: tb/aon_sec_counter_bench.sv
`timescale 1ns/1ps
module aon_sec_counter_bench;
  logic        clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  aon_sec_counter u_aon_sec_counter (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #2 clk = ~clk;
  always #21 slow_clk = ~slow_clk;

  localparam logic [5:0] CTRL = 6'h04, STAT = 6'h18, CHI = 6'h1C,
                         CLO = 6'h20, ALRM = 6'h24, GRD = 6'h30;

  typedef struct {
    logic        is_irq;
    logic [31:0] exp;
    logic [31:0] mask;
    string       tag;
  } item_t;
  item_t sbq[$];
  event  ev_sample;
  int    n_run = 0, n_fail = 0;
  bit    done = 0;

  always begin
    @(ev_sample);
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sbq.pop_front();
      act = it.is_irq ? {31'b0, irq} : bus_rdata;
      n_run++;
      if ((act & it.mask) !== (it.exp & it.mask)) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act & it.mask, it.exp & it.mask);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic chk(input logic [5:0] a, input logic [31:0] e, input logic [31:0] m, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.is_irq = 0; it.exp = e; it.mask = m; it.tag = tag;
    sbq.push_back(it);
    #1 ->ev_sample;
    #0.5;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1; it.exp = {31'b0, e}; it.mask = 32'h1; it.tag = tag;
    sbq.push_back(it);
    #1 ->ev_sample;
    #0.5;
  endtask

  task automatic direct(input bit ok, input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_cnt(output logic [63:0] v);
    logic [31:0] h1, l1, h2, l2;
    for (int k = 0; k < 20; k++) begin
      rd(CHI, h1); rd(CLO, l1); rd(CHI, h2); rd(CLO, l2);
      if (h1 == h2 && l1 == l2) break;
    end
    v = {h1, l1};
  endtask

  task automatic wait_slow(input int n);
    repeat (n) @(posedge slow_clk);
  endtask

  task automatic load(input logic [63:0] v);
    wr(CLO, v[31:0]);
    wr(CHI, v[63:32]);
    wait_slow(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] s1, s2;
    logic [63:0] v1, v2, a, b;
    s1 = 32'h12345678;
    s2 = 32'h00ABCDEF;
    v1 = ({32'b0, s1} << 15) | 64'h7FF8;
    v2 = ({32'b0, s2} << 15) | 64'h7FF0;

    repeat (4) @(posedge clk);
    rst_n = 1;
    wait_slow(2);

    chk(CTRL, 0, '1, "R1 ctrl reset");
    chk(STAT, 0, '1, "R1 stat reset");
    chk(CHI, 0, '1, "R1 cnt hi reset");
    chk(CLO, 0, '1, "R1 cnt lo reset");
    chk(ALRM, 0, '1, "R1 alarm reset");
    chk(GRD, 0, '1, "R1 guard reset");
    chk_irq(0, "R1 irq reset");

    wr(GRD, 32'h41736166);
    chk(GRD, 32'h41736166, '1, "R2 guard readback");
    chk(6'h08, 0, '1, "R2 unmapped reads zero");

    load(v1);
    chk(CHI, v1[63:32], '1, "R4 load hi while stopped");
    chk(CLO, v1[31:0], '1, "R3 load lo while stopped");

    wr(CTRL, 32'h1);
    chk(CTRL, 0, 32'h1, "R5 run readback not immediate");
    wait_slow(3);
    chk(CTRL, 1, 32'h1, "R5 run readback within 3 slow");

    wr(CHI, 32'h7FFF);
    wr(CLO, 32'h0);
    wait_slow(4);
    chk(CHI, v1[63:32], '1, "R4 hi write ignored while running");
    rd_cnt(a);
    direct(a[46:15] >= s1 && a[46:15] <= s1 + 1, a[46:15], s1, "R4 lo write ignored while running");
    wait_slow(10);
    rd_cnt(a);
    direct(a[46:15] == s1 + 1, a[46:15], s1 + 1, "R10 coherent seconds after rollover");
    wait_slow(5);
    rd_cnt(b);
    direct((b - a) >= 4 && (b - a) <= 6, b - a, 5, "R3 advances one per slow tick");

    wr(CTRL, 32'h0);
    wait_slow(4);
    chk(CTRL, 0, 32'h1, "R5 run readback clears");
    rd_cnt(a);
    wait_slow(5);
    rd_cnt(b);
    direct(a == b, b, a, "R3 counter holds while stopped");

    load(v2);
    wr(ALRM, s2 + 1);
    chk(ALRM, s2 + 1, '1, "R6 alarm write while disarmed");
    wr(CTRL, 32'hB);
    chk(CTRL, 32'hA, 32'hA, "R5 alarm and wake bits read back at once");
    chk_irq(0, "R9 irq low before match");
    wait_slow(6);
    chk(STAT, 0, '1, "R7 no flag before match");
    wr(ALRM, 32'hDEAD);
    chk(ALRM, s2 + 1, '1, "R6 alarm write ignored while armed");
    wait_slow(30);
    chk(STAT, 1, '1, "R7 flag on seconds match");
    chk_irq(1, "R9 irq with both enables");

    wr(CTRL, 32'h3);
    chk_irq(0, "R9 irq off without wake enable");
    chk(STAT, 1, '1, "R8 flag sticky");
    wr(CTRL, 32'hB);
    chk_irq(1, "R9 irq back with wake enable");
    wr(STAT, 32'h2);
    chk(STAT, 1, '1, "R8 write without bit0 no effect");
    wr(STAT, 32'h1);
    chk(STAT, 0, '1, "R8 write one clears");
    chk_irq(0, "R9 irq low after clear");
    wait_slow(10);
    chk(STAT, 0, '1, "R8 stays clear within matching second");

    wr(CTRL, 32'h9);
    wait_slow(4);
    wr(ALRM, s2 + 1);
    wr(CTRL, 32'hB);
    wait_slow(6);
    chk(STAT, 1, '1, "R7 arming during match sets flag");
    wr(STAT, 32'hFFFFFFFF);
    chk(STAT, 0, '1, "R8 all ones clears");

    #5;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule